// File: doc/BRIEF.md
# Presence-Vector Home Directory Controller

This block sits at the home node of a distributed shared-memory machine with a fixed number of processors. For every memory block homed at this node it keeps one presence bit per processor and one dirty bit. Processors send it read misses, write misses and dirty-line writebacks. It then reads local memory, recalls the line from the current owner, or invalidates the current sharers, as the entry requires. After that it updates the entry and answers the requester with the line data.

Only one block transaction is served at a time. Outgoing coherence messages (share-recall, invalidating recall, invalidate) leave on a single message port, one per cycle. Replies to them come back on one acknowledgement port, which carries the line data when it answers a recall. Local memory is a simple synchronous port with one cycle of read latency.

Top module: `dirn_home_ctrl`

## Requirements
- R1: After reset `req_ready` is high, and `msg_valid` and `reply_valid` are low. Every directory entry is uncached: no presence bits are set and the dirty bit is clear.
- R2: A read (op code 0) to a clean entry sends no message. It reads memory, replies to the requester with the memory data, and adds the requester to the presence vector.
- R3: A read to a dirty entry sends one share-recall (message kind 1) to the owner and waits for its acknowledgement data. It writes that data to memory and replies with it to the requester. The entry becomes clean, with both the old owner and the requester present.
- R4: A write (op code 1) to a clean entry sends one invalidate (message kind 3) to each present processor other than the requester, in ascending processor order, one per cycle. It then replies with the memory data.
- R5: The reply to a write to a clean entry is issued only after the number of acknowledgements received equals the number of invalidates sent. The count holds whether acknowledgements arrive while invalidates are still being issued or only later.
- R6: After any write completes, the entry is dirty and its presence vector holds only the writer.
- R7: A write to an entry that is dirty at another processor sends one invalidating recall (message kind 2) to that owner. The recalled data is written to memory and returned to the requester, and ownership moves to the requester.
- R8: A writeback (op code 2) from the current owner of a dirty entry writes its data to memory, sends no reply and no message, and returns the entry to uncached.
- R9: A writeback from a processor that is not the dirty owner is ignored. Memory and the directory entry are unchanged.
- R10: From acceptance of a request until its transaction ends, `req_ready` is low. This includes every cycle that carries a message or a reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 writeback |
| req_src | input | PW | Requesting processor |
| req_addr | input | AW | Block index |
| req_data | input | DATA_W | Writeback data |
| msg_valid | output | 1 | Coherence message out |
| msg_kind | output | 2 | 1 share-recall, 2 invalidating recall, 3 invalidate |
| msg_dst | output | PW | Target processor |
| msg_addr | output | AW | Block index of the message |
| ack_valid | input | 1 | Acknowledgement from a cache |
| ack_data | input | DATA_W | Line data carried by a recall acknowledgement |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory block index |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after a read strobe |
| reply_valid | output | 1 | Data reply to requester |
| reply_dst | output | PW | Requester receiving the reply |
| reply_data | output | DATA_W | Line data |

## Verification
The critical overlap is the issuing of an invalidate in the same cycle as the acknowledgement of the previous one. Both the issue counter and the acknowledgement counter advance on that edge, and an early or doubled count would release the write reply too soon. The bench provokes this by acknowledging each invalidate on the very next edge for even-numbered blocks, while for odd-numbered blocks it holds all acknowledgements until several quiet cycles after the last invalidate. In both cases it judges the result by comparing the acknowledgements it has handed out with the number of invalidates seen, at the cycle the reply appears.

// File: rtl/dirn_pkg.sv
package dirn_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_WBACK = 2'd2,
    OP_RSVD  = 2'd3
  } req_op_e;

  typedef enum logic [1:0] {
    MK_NONE       = 2'd0,
    MK_RECALL_SH  = 2'd1,
    MK_RECALL_INV = 2'd2,
    MK_INVAL      = 2'd3
  } msg_kind_e;

  // index of the lowest set bit (0 when none)
  function automatic int unsigned lowest_set(input logic [31:0] v);
    int unsigned idx;
    idx = 0;
    for (int k = 31; k >= 0; k--) begin
      if (v[k]) idx = k;
    end
    return idx;
  endfunction

  function automatic int unsigned count_ones(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int k = 0; k < 32; k++) n += v[k];
    return n;
  endfunction

endpackage

// File: rtl/dirn_entry_store.sv
module dirn_entry_store
  import dirn_pkg::*;
#(
  parameter int NBLK  = 8,
  parameter int NPROC = 4,
  localparam int AW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_addr,
  output logic [NPROC-1:0] rd_pres,
  output logic             rd_dirty,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [NPROC-1:0] wr_pres,
  input  logic             wr_dirty
);

  logic [NPROC-1:0] pres_all  [NBLK];
  logic             dirty_all [NBLK];

  for (genvar b = 0; b < NBLK; b++) begin : g_entry
    logic [NPROC-1:0] pres_r;
    logic             dirty_r;
    wire              hit = wr_en && (wr_addr == AW'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pres_r  <= '0;
        dirty_r <= 1'b0;
      end else if (hit) begin
        pres_r  <= wr_pres;
        dirty_r <= wr_dirty;
      end
    end

    assign pres_all[b]  = pres_r;
    assign dirty_all[b] = dirty_r;
  end

  assign rd_pres  = pres_all[rd_addr];
  assign rd_dirty = dirty_all[rd_addr];

  // a dirty entry always names exactly one holder
  assert_dirty_single_holder_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_dirty) |-> $onehot(wr_pres))
    else $error("dirty entry written with presence not one-hot");

endmodule

// File: rtl/dirn_inval_seq.sv
module dirn_inval_seq
  import dirn_pkg::*;
#(
  parameter int NPROC = 4,
  localparam int PW   = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int CW   = $clog2(NPROC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NPROC-1:0] target,
  input  logic             ack_in,
  output logic             send_valid,
  output logic [PW-1:0]    send_dst,
  output logic             all_acked,
  output logic             pending
);

  logic [NPROC-1:0] remain_q;
  logic [NPROC-1:0] low_bit;
  logic [CW-1:0]    sent_q;
  logic [CW-1:0]    acked_q;

  assign low_bit    = remain_q & (~remain_q + NPROC'(1));
  assign send_valid = |remain_q;
  assign send_dst   = PW'(lowest_set(32'(remain_q)));
  assign all_acked  = !send_valid && (acked_q == sent_q);
  assign pending    = !all_acked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
      sent_q   <= '0;
      acked_q  <= '0;
    end else if (start) begin
      remain_q <= target;
      sent_q   <= '0;
      acked_q  <= '0;
    end else begin
      if (send_valid) begin
        remain_q <= remain_q & ~low_bit;
        sent_q   <= sent_q + CW'(1);
      end
      if (ack_in) acked_q <= acked_q + CW'(1);
    end
  end

  assert_ack_not_ahead_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acked_q <= sent_q)
    else $error("more invalidate acknowledgements than invalidates");

endmodule

// File: rtl/dirn_home_ctrl.sv
module dirn_home_ctrl
  import dirn_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int NBLK   = 8,
  parameter int DATA_W = 16,
  localparam int PW    = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int AW    = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [PW-1:0]     req_src,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              msg_valid,
  output logic [1:0]        msg_kind,
  output logic [PW-1:0]     msg_dst,
  output logic [AW-1:0]     msg_addr,
  input  logic              ack_valid,
  input  logic [DATA_W-1:0] ack_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              reply_valid,
  output logic [PW-1:0]     reply_dst,
  output logic [DATA_W-1:0] reply_data
);

  typedef enum logic [2:0] {
    S_IDLE, S_INV, S_RD, S_RDW, S_RCL_SEND, S_RCL_WAIT, S_WB
  } st_e;

  st_e               st_q, st_d;
  req_op_e           op_q;
  logic [PW-1:0]     src_q;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] data_q;

  // directory lookup and update
  logic [AW-1:0]     look_addr;
  logic [NPROC-1:0]  ent_pres;
  logic              ent_dirty;
  logic              upd_en;
  logic [NPROC-1:0]  upd_pres;
  logic              upd_dirty;

  // named events
  logic              accept;
  logic              wb_hit;
  logic [NPROC-1:0]  req_bit;
  logic [NPROC-1:0]  src_bit;
  logic [PW-1:0]     owner;
  logic              inv_start;
  logic [NPROC-1:0]  inv_target;
  logic              inv_send;
  logic [PW-1:0]     inv_dst;
  logic              inv_all_acked;
  logic              inv_pending;
  logic              inv_ack;
  msg_kind_e         kind_w;

  assign look_addr  = (st_q == S_IDLE) ? req_addr : addr_q;
  assign accept     = req_valid && (st_q == S_IDLE);
  assign req_bit    = NPROC'(1) << req_src;
  assign src_bit    = NPROC'(1) << src_q;
  assign owner      = PW'(lowest_set(32'(ent_pres)));
  assign wb_hit     = ent_dirty && ent_pres[req_src];
  assign inv_start  = accept && (req_op_e'(req_op) == OP_WRITE) && !ent_dirty;
  assign inv_target = ent_pres & ~req_bit;
  assign inv_ack    = ack_valid && (st_q == S_INV);

  dirn_entry_store #(.NBLK(NBLK), .NPROC(NPROC)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_addr  (look_addr),
    .rd_pres  (ent_pres),
    .rd_dirty (ent_dirty),
    .wr_en    (upd_en),
    .wr_addr  (addr_q),
    .wr_pres  (upd_pres),
    .wr_dirty (upd_dirty)
  );

  dirn_inval_seq #(.NPROC(NPROC)) inval_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (inv_start),
    .target     (inv_target),
    .ack_in     (inv_ack),
    .send_valid (inv_send),
    .send_dst   (inv_dst),
    .all_acked  (inv_all_acked),
    .pending    (inv_pending)
  );

  // sequencing
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          unique case (req_op_e'(req_op))
            OP_READ:  st_d = ent_dirty ? S_RCL_SEND : S_RD;
            OP_WRITE: st_d = ent_dirty ? S_RCL_SEND : S_INV;
            OP_WBACK: st_d = wb_hit ? S_WB : S_IDLE;
            default:  st_d = S_IDLE;
          endcase
        end
      end
      S_INV:      if (inv_all_acked) st_d = S_RD;
      S_RD:       st_d = S_RDW;
      S_RDW:      st_d = S_IDLE;
      S_RCL_SEND: st_d = S_RCL_WAIT;
      S_RCL_WAIT: if (ack_valid) st_d = S_WB;
      S_WB:       st_d = S_IDLE;
      default:    st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      op_q   <= OP_READ;
      src_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        op_q   <= req_op_e'(req_op);
        src_q  <= req_src;
        addr_q <= req_addr;
        data_q <= req_data;
      end else if (st_q == S_RCL_WAIT && ack_valid) begin
        data_q <= ack_data;
      end
    end
  end

  // outputs
  assign req_ready = (st_q == S_IDLE);

  always_comb begin
    msg_valid = 1'b0;
    kind_w    = MK_NONE;
    msg_dst   = '0;
    if (st_q == S_INV && inv_send) begin
      msg_valid = 1'b1;
      kind_w    = MK_INVAL;
      msg_dst   = inv_dst;
    end else if (st_q == S_RCL_SEND) begin
      msg_valid = 1'b1;
      kind_w    = (op_q == OP_WRITE) ? MK_RECALL_INV : MK_RECALL_SH;
      msg_dst   = owner;
    end
  end
  assign msg_kind = kind_w;
  assign msg_addr = addr_q;

  assign mem_en    = (st_q == S_RD) || (st_q == S_WB);
  assign mem_we    = (st_q == S_WB);
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;

  always_comb begin
    reply_valid = 1'b0;
    reply_data  = '0;
    if (st_q == S_RDW) begin
      reply_valid = 1'b1;
      reply_data  = mem_rdata;
    end else if (st_q == S_WB && op_q != OP_WBACK) begin
      reply_valid = 1'b1;
      reply_data  = data_q;
    end
  end
  assign reply_dst = src_q;

  // entry update at the closing cycle of a transaction
  always_comb begin
    upd_en    = (st_q == S_RDW) || (st_q == S_WB);
    upd_pres  = ent_pres;
    upd_dirty = ent_dirty;
    unique case (op_q)
      OP_READ:  begin upd_pres = ent_pres | src_bit; upd_dirty = 1'b0; end
      OP_WRITE: begin upd_pres = src_bit;            upd_dirty = 1'b1; end
      OP_WBACK: begin upd_pres = '0;                 upd_dirty = 1'b0; end
      default:  begin upd_pres = ent_pres;           upd_dirty = ent_dirty; end
    endcase
  end

  // checks next to the logic they guard
  assert_inval_skips_requester_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind == MK_INVAL) |-> (msg_dst != src_q))
    else $error("invalidate aimed at the requester");

  assert_write_reply_after_acks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_valid && op_q == OP_WRITE) |-> inv_all_acked)
    else $error("write reply before all acknowledgements");

  assert_recall_hits_holder_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_kind != MK_INVAL) |-> (ent_dirty && ent_pres[msg_dst]))
    else $error("recall sent to a non-owner");

  assert_busy_while_inval_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_pending |-> !req_ready)
    else $error("ready while invalidation round open");

  assert_reply_not_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_valid || msg_valid) |=> $stable(addr_q) || req_ready)
    else $error("transaction address changed mid-flight");

endmodule

// File: tb/dirn_home_ctrl_tb.sv
module dirn_home_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NPROC  = 4;
  localparam int NBLK   = 8;
  localparam int DATA_W = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [1:0]  req_src = '0;
  logic [2:0]  req_addr = '0;
  logic [15:0] req_data = '0;
  logic        msg_valid;
  logic [1:0]  msg_kind;
  logic [1:0]  msg_dst;
  logic [2:0]  msg_addr;
  logic        ack_valid = 1'b0;
  logic [15:0] ack_data = '0;
  logic        mem_en, mem_we;
  logic [2:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        reply_valid;
  logic [1:0]  reply_dst;
  logic [15:0] reply_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dirn_home_ctrl #(.NPROC(NPROC), .NBLK(NBLK), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_src(req_src), .req_addr(req_addr), .req_data(req_data),
    .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dst(msg_dst), .msg_addr(msg_addr),
    .ack_valid(ack_valid), .ack_data(ack_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .reply_valid(reply_valid), .reply_dst(reply_dst), .reply_data(reply_data)
  );

  // memory model with one cycle read latency
  logic [15:0] bmem [NBLK];
  function automatic logic [15:0] mem_init(input int b);
    return 16'h1000 + 16'(b * 16'h0111);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) bmem[b] <= mem_init(b);
      mem_rdata <= '0;
    end else if (mem_en) begin
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      else        mem_rdata <= bmem[mem_addr];
    end
  end

  // reference directory model
  logic [3:0]  m_pres  [NBLK];
  logic        m_dirty [NBLK];
  logic [15:0] m_mem   [NBLK];
  logic [15:0] own_val [NBLK];

  int total = 0;
  int bad   = 0;
  int txn_no = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  function automatic int owner_of(input logic [3:0] p);
    int o = 0;
    for (int k = NPROC - 1; k >= 0; k--) if (p[k]) o = k;
    return o;
  endfunction

  function automatic int ones(input logic [3:0] p);
    int n = 0;
    for (int k = 0; k < NPROC; k++) n += p[k];
    return n;
  endfunction

  localparam logic [1:0] OPR = 2'd0, OPW = 2'd1, OPB = 2'd2;

  task automatic run_txn(input logic [1:0] op, input int src, input int addr,
                         input logic [15:0] wdat, input int gap);
    logic [3:0]  inv_mask = '0;
    int          inv_cnt = 0, last_dst = -1, rcl_cnt = 0, rcl_kind = 0, rcl_dst = 0;
    int          rep_cnt = 0, rep_dst = 0, acks_given = 0, acks_at_reply = 0;
    int          owed = 0, quiet = 0, rcl_timer = -1, cycles = 0;
    logic [15:0] rep_data = '0;
    bit          order_ok = 1, ready_bad = 0, addr_ok = 1;
    logic [3:0]  sbit = 4'(1 << src);
    logic [3:0]  p0 = m_pres[addr];
    bit          d0 = m_dirty[addr];
    int          own = owner_of(p0);

    txn_no++;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_op = op; req_src = 2'(src);
    req_addr = 3'(addr); req_data = wdat;
    @(posedge clk);
    while (cycles < 100) begin
      @(negedge clk);
      cycles++;
      req_valid = 1'b0;
      ack_valid = 1'b0;
      if (msg_valid) begin
        if (req_ready) ready_bad = 1;
        if (msg_addr != 3'(addr)) addr_ok = 0;
        if (msg_kind == 2'd3) begin
          inv_mask[msg_dst] = 1'b1;
          inv_cnt++;
          if (int'(msg_dst) <= last_dst) order_ok = 0;
          last_dst = msg_dst;
          owed++;
          quiet = 0;
        end else begin
          rcl_cnt++;
          rcl_kind = msg_kind;
          rcl_dst  = msg_dst;
          rcl_timer = 2;
          quiet++;
        end
      end else begin
        quiet++;
      end
      if (owed > 0 && quiet >= gap) begin
        ack_valid = 1'b1; owed--; acks_given++;
      end
      if (rcl_timer == 0) begin
        ack_valid = 1'b1; ack_data = own_val[addr];
      end
      if (rcl_timer >= 0) rcl_timer--;
      if (reply_valid) begin
        if (req_ready) ready_bad = 1;
        rep_cnt++; rep_dst = reply_dst; rep_data = reply_data;
        acks_at_reply = acks_given;
      end
      if (req_ready && !ack_valid) break;
    end
    ack_valid = 1'b0;
    chk(cycles < 100, "R10", "transaction ends", cycles, 0);
    chk(!ready_bad, "R10", "ready low while busy", int'(ready_bad), 0);
    chk(addr_ok, "R11", "message block index", int'(addr_ok), 1);

    if (op == OPR) begin
      chk(rep_cnt == 1 && rep_dst == src, "R2", "read reply to requester", rep_dst, src);
      if (!d0) begin
        chk(rcl_cnt == 0 && inv_cnt == 0, "R2", "clean read sends nothing", rcl_cnt + inv_cnt, 0);
        chk(rep_data == m_mem[addr], "R2", "clean read data", rep_data, m_mem[addr]);
        m_pres[addr] = p0 | sbit;
      end else begin
        chk(rcl_cnt == 1 && rcl_dst == own, "R3/R6", "recall to sole owner", rcl_dst, own);
        chk(rcl_kind == 1, "R3", "share-recall kind", rcl_kind, 1);
        chk(inv_cnt == 0, "R3", "no invalidates", inv_cnt, 0);
        chk(rep_data == own_val[addr], "R3", "recalled data forwarded", rep_data, own_val[addr]);
        chk(bmem[addr] == own_val[addr], "R3", "memory updated", bmem[addr], own_val[addr]);
        m_mem[addr] = own_val[addr];
        m_pres[addr] = p0 | sbit;
        m_dirty[addr] = 1'b0;
      end
    end else if (op == OPW) begin
      chk(rep_cnt == 1 && rep_dst == src, "R4", "write reply to requester", rep_dst, src);
      if (!d0) begin
        chk(inv_mask == (p0 & ~sbit), "R4", "invalidate set", inv_mask, p0 & ~sbit);
        chk(inv_cnt == ones(p0 & ~sbit), "R4", "one invalidate each", inv_cnt, ones(p0 & ~sbit));
        chk(order_ok, "R4", "ascending order", int'(order_ok), 1);
        chk(rcl_cnt == 0, "R4", "no recall on clean write", rcl_cnt, 0);
        chk(rep_data == m_mem[addr], "R4", "write data from memory", rep_data, m_mem[addr]);
        chk(acks_at_reply == inv_cnt, "R5", "acks before reply", acks_at_reply, inv_cnt);
      end else begin
        chk(rcl_cnt == 1 && rcl_dst == own && rcl_kind == 2, "R7/R6", "invalidating recall to owner",
            rcl_dst * 16 + rcl_kind, own * 16 + 2);
        chk(inv_cnt == 0, "R7", "no invalidates", inv_cnt, 0);
        chk(rep_data == own_val[addr], "R7", "recalled data to writer", rep_data, own_val[addr]);
        chk(bmem[addr] == own_val[addr], "R7", "memory refreshed", bmem[addr], own_val[addr]);
        m_mem[addr] = own_val[addr];
      end
      m_pres[addr] = sbit;
      m_dirty[addr] = 1'b1;
      own_val[addr] = 16'hC000 ^ 16'(addr * 256) ^ 16'(src * 16) ^ 16'(txn_no);
    end else begin
      chk(rep_cnt == 0 && rcl_cnt == 0 && inv_cnt == 0, (d0 && p0[src]) ? "R8" : "R9",
          "writeback is silent", rep_cnt + rcl_cnt + inv_cnt, 0);
      if (d0 && p0[src]) begin
        chk(bmem[addr] == wdat, "R8", "writeback stored", bmem[addr], wdat);
        m_mem[addr] = wdat;
        m_pres[addr] = '0;
        m_dirty[addr] = 1'b0;
      end else begin
        chk(bmem[addr] == m_mem[addr], "R9", "stale writeback ignored", bmem[addr], m_mem[addr]);
      end
    end
  endtask

  initial begin
    for (int b = 0; b < NBLK; b++) begin
      m_pres[b] = '0; m_dirty[b] = 1'b0; m_mem[b] = mem_init(b); own_val[b] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready in reset", int'(req_ready), 1);
    chk(!msg_valid && !reply_valid, "R1", "quiet in reset", int'(msg_valid) + int'(reply_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !msg_valid && !reply_valid, "R1", "idle after reset", int'(req_ready), 1);

    for (int b = 0; b < NBLK; b++) begin
      int a = b % 4, c1 = (b + 1) % 4, c2 = (b + 2) % 4, c3 = (b + 3) % 4;
      int gap = (b % 2 == 1) ? 3 : 0;
      run_txn(OPR, a,  b, 16'h0, gap);
      run_txn(OPR, c1, b, 16'h0, gap);
      run_txn(OPR, c2, b, 16'h0, gap);
      run_txn(OPW, c3, b, 16'h0, gap);            // invalidates three sharers
      run_txn(OPR, a,  b, 16'h0, gap);            // recall from writer
      run_txn(OPW, c1, b, 16'h0, gap);            // invalidates writer and reader
      run_txn(OPW, c2, b, 16'h0, gap);            // ownership transfer
      run_txn(OPB, a,  b, 16'hDEAD, gap);         // not the owner
      run_txn(OPR, c3, b, 16'h0, gap);            // still recalls from c2
      run_txn(OPW, a,  b, 16'h0, gap);
      run_txn(OPB, a,  b, own_val[b], gap);       // owner writeback
      run_txn(OPW, c1, b, 16'h0, gap);            // uncached: no invalidates
      run_txn(OPR, c2, b, 16'h0, gap);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule